// File: doc/BRIEF.md
# Programmable Divided Countdown Timer

This block is a down-counting interval timer that runs from the bus clock. Software programs three registers: a divide setting that picks how many bus clocks make one timer tick, an initial count, and a control word that carries an interrupt vector, a mask bit and a mode bit that selects periodic or one-shot operation. A fourth read-only location returns the live count.

When a count period of initial count plus one ticks has elapsed, the block raises a single-cycle event pulse, with the programmed vector beside it, toward the interrupt logic. In periodic mode the count reloads and the period repeats. In one-shot mode the count rests at zero after one event. An initial count of zero never produces an event. Setting the mask suppresses events, while the count keeps running underneath.

Top module: `divided_countdown_timer`

## Requirements
- R1: After reset the divide register reads 0, the initial count reads 0, the current count reads 0 and the control word reads 0x0001_0000, with only the mask set.
- R2: Register select codes for both write and read are 0 for divide, 1 for initial count and 2 for control. A divide write stores only data bits 3, 1 and 0, so writing 0xFF reads back 0xB.
- R3: The divide code is the 3-bit value {bit3, bit1, bit0} of the divide register. One tick lasts 2^((code+1) mod 8) bus clocks: 0x0 gives 2 clocks, 0x3 gives 16, 0xA gives 128 and 0xB gives 1.
- R4: In the control word, bits 7:0 hold the vector, bit 16 the mask and bit 17 the mode (1 = periodic). All other bits read as 0.
- R5: Writing the initial count restarts counting at that clock edge. The current count equals the written value and drops by one per tick from there.
- R6: In one-shot mode exactly one event fires on the edge at which initial count + 1 ticks have elapsed since the load. The current count saturates at 0.
- R7: In periodic mode an event fires every initial count + 1 ticks, and the current count reloads to the initial count on each event.
- R8: With an initial count of 0, no event fires in either mode.
- R9: No event fires while the mask is set. A one-shot expiry that occurs while masked is lost and does not fire when the mask is later cleared.
- R10: Each event is a one-clock pulse on evt_pulse, and evt_vector equals the control-word vector during that pulse.
- R11: Read select 3 returns the current count without disturbing it. A write with select 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | DATA_W | Read data (combinational) |
| evt_pulse | output | 1 | One-cycle timer event |
| evt_vector | output | 8 | Vector accompanying the event |

## Verification
A write takes effect on the clock edge that samples it, so register readback and the restarted count are visible in the half-cycle that follows that edge. The event for a load on edge E with N clocks per tick is due exactly after edge E + (count+1)*N. In periodic mode each later event is due N*(count+1) edges after the previous one. The driver records the edge number of every load and queues the due edge and vector of each expected event. A monitor sampling on the falling edge matches every pulse against the head of that queue, flags any pulse that is not expected, and flags any expected pulse whose edge passes without one. Masked and zero-count windows are checked both by the absence of pulses and by a pulse counter that must not move.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
   localparam int VEC_W    = 8;
   localparam int MASK_BIT = 16;
   localparam int PER_BIT  = 17;
   localparam int SHIFT_W  = 3;
   localparam int PRE_W    = (1 << SHIFT_W) - 1;

   typedef enum logic [1:0] {
      SEL_DIV  = 2'd0,
      SEL_INIT = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_CUR  = 2'd3
   } dtmr_sel_e;

   // code {d3,d1,d0}; clocks per tick are 2^((code+1) mod 8)
   function automatic logic [SHIFT_W-1:0] div_shift(input logic [3:0] d);
      logic [SHIFT_W-1:0] code;
      code = {d[3], d[1:0]};
      return code + 3'd1;
   endfunction
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler
   import dtmr_pkg::*;
#(
   parameter int P_W = PRE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic [SHIFT_W-1:0] shift,
   output logic               tick
);
   logic [P_W-1:0] pre_q;
   logic [P_W-1:0] limit;

   assign limit = ~({P_W{1'b1}} << shift);
   assign tick  = !restart && (pre_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)
         pre_q <= '0;
      else if (restart || pre_q >= limit)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/dtmr_counter.sv
module dtmr_counter
   import dtmr_pkg::*;
#(
   parameter int  CNT_W    = 32,
   parameter bit  VEC_HOLD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload_val,
   input  logic             tick,
   input  logic             periodic,
   input  logic             masked,
   input  logic [VEC_W-1:0] vec_in,
   output logic [CNT_W-1:0] cnt,
   output logic             fire,
   output logic [VEC_W-1:0] vec_out
);
   logic [CNT_W-1:0] cnt_q;
   logic             spent_q;
   logic             fire_q;
   logic [VEC_W-1:0] vec_q;
   logic             at_zero;
   logic             live;
   logic             fire_now;

   assign at_zero  = (cnt_q == '0);
   assign live     = (reload_val != '0) && (periodic || !spent_q);
   assign fire_now = !load && tick && at_zero && live && !masked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         spent_q <= 1'b0;
         fire_q  <= 1'b0;
         vec_q   <= '0;
      end else begin
         fire_q <= fire_now;
         if (fire_now)
            vec_q <= vec_in;
         if (load) begin
            cnt_q   <= load_val;
            spent_q <= 1'b0;
         end else if (tick) begin
            if (!at_zero)
               cnt_q <= cnt_q - 1'b1;
            else if (periodic)
               cnt_q <= reload_val;
            else
               spent_q <= 1'b1;
         end
      end
   end

   assign cnt  = cnt_q;
   assign fire = fire_q;

   generate
      if (VEC_HOLD) begin : g_vec_hold
         assign vec_out = vec_q;
      end else begin : g_vec_gate
         assign vec_out = fire_q ? vec_q : '0;
      end
   endgenerate
endmodule

// File: rtl/divided_countdown_timer.sv
module divided_countdown_timer
   import dtmr_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit VEC_HOLD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [1:0]        rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              evt_pulse,
   output logic [VEC_W-1:0]  evt_vector
);
   generate
      if (DATA_W < PER_BIT + 1) begin : g_bad_width
         $error("DATA_W too narrow for the control word");
      end
   endgenerate

   logic [3:0]        div_q;
   logic [DATA_W-1:0] init_q;
   logic [VEC_W-1:0]  vec_q;
   logic              mask_q;
   logic              per_q;
   logic [DATA_W-1:0] cur_cnt;
   logic              load;
   logic              tick;

   assign load = wr_en && (wr_sel == SEL_INIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_q  <= '0;
         init_q <= '0;
         vec_q  <= '0;
         mask_q <= 1'b1;
         per_q  <= 1'b0;
      end else if (wr_en) begin
         case (wr_sel)
            SEL_DIV:  div_q  <= {wr_data[3], 1'b0, wr_data[1:0]};
            SEL_INIT: init_q <= wr_data;
            SEL_CTRL: begin
               vec_q  <= wr_data[VEC_W-1:0];
               mask_q <= wr_data[MASK_BIT];
               per_q  <= wr_data[PER_BIT];
            end
            default: ;
         endcase
      end
   end

   dtmr_prescaler #(.P_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (load),
      .shift   (div_shift(div_q)),
      .tick    (tick)
   );

   dtmr_counter #(.CNT_W(DATA_W), .VEC_HOLD(VEC_HOLD)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (load),
      .load_val   (wr_data),
      .reload_val (init_q),
      .tick       (tick),
      .periodic   (per_q),
      .masked     (mask_q),
      .vec_in     (vec_q),
      .cnt        (cur_cnt),
      .fire       (evt_pulse),
      .vec_out    (evt_vector)
   );

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_DIV:  rd_data[3:0] = div_q;
         SEL_INIT: rd_data = init_q;
         SEL_CTRL: begin
            rd_data[VEC_W-1:0] = vec_q;
            rd_data[MASK_BIT]  = mask_q;
            rd_data[PER_BIT]   = per_q;
         end
         default:  rd_data = cur_cnt;
      endcase
   end
endmodule

// File: rtl/dtmr_chk.sv
module dtmr_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic [1:0]        rd_sel,
   input logic [DATA_W-1:0] rd_data,
   input logic              evt_pulse,
   input logic [DATA_W-1:0] init_q,
   input logic [DATA_W-1:0] cur_cnt,
   input logic              mask_q,
   input logic              per_q
);
   // R10
   pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |=> !evt_pulse);

   // R2
   div_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 2'd0) |-> ((rd_data & ~DATA_W'(4'hB)) == '0));

   // R9
   mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |-> !$past(mask_q));

   // R8
   zero_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_pulse |-> ($past(init_q) != '0));

   // R5
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=> (cur_cnt == $past(wr_data)));

   // R6
   saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!per_q && cur_cnt == '0 && !(wr_en && wr_sel == 2'd1)) |=> (cur_cnt == '0));
endmodule

bind divided_countdown_timer dtmr_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_sel    (wr_sel),
   .wr_data   (wr_data),
   .rd_sel    (rd_sel),
   .rd_data   (rd_data),
   .evt_pulse (evt_pulse),
   .init_q    (init_q),
   .cur_cnt   (cur_cnt),
   .mask_q    (mask_q),
   .per_q     (per_q)
);

// File: tb/divided_countdown_timer_test.sv
`timescale 1ns/1ps
module divided_countdown_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [1:0]  rd_sel = 2'd0;
   logic [31:0] rd_data;
   logic        evt_pulse;
   logic [7:0]  evt_vector;

   divided_countdown_timer uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .evt_pulse(evt_pulse), .evt_vector(evt_vector)
   );

   always #2.5 clk = ~clk;

   typedef struct {
      int         t;
      logic [7:0] v;
      string      req;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   checks = 0;
   int   fails = 0;
   int   pulses = 0;
   int   last_edge = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      last_edge = cyc + 1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input string req, input logic [1:0] sel, input logic [31:0] exp);
      rd_sel = sel;
      #0.1;
      chk(req, rd_data, exp);
   endtask

   task automatic push(input int t, input logic [7:0] v, input string req);
      exp_t e;
      e.t = t; e.v = v; e.req = req;
      q.push_back(e);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: compare each pulse with the head of the expectation queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (evt_pulse) begin
            pulses++;
            if (q.size() == 0) begin
               checks++; fails++;
               $display("FAIL R10 unexpected pulse at edge %0d actual=1 expected=0", cyc);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk({e.req, " time"}, cyc, e.t);
               chk("R10 vector", {24'h0, evt_vector}, {24'h0, e.v});
            end
         end else if (q.size() > 0 && cyc > q[0].t) begin
            exp_t e;
            e = q.pop_front();
            checks++; fails++;
            $display("FAIL %s missed pulse actual=none expected=edge %0d", e.req, e.t);
         end
      end
   end

   initial begin
      int e0;
      int p0;
      idle(4);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      rd("R1 div", 2'd0, 32'h0);
      rd("R1 init", 2'd1, 32'h0);
      rd("R1 ctrl", 2'd2, 32'h0001_0000);
      rd("R1 cur", 2'd3, 32'h0);
      chk("R1 pulse", {31'h0, evt_pulse}, 32'h0);

      // R2 divide bit filtering; 0xB gives one clock per tick
      wr(2'd0, 32'hFF);
      rd("R2 div", 2'd0, 32'hB);

      // R4 control fields
      wr(2'd2, 32'hFFFF_FF42);
      rd("R4 ctrl all", 2'd2, 32'h0003_0042);
      wr(2'd2, 32'h0000_0042);
      rd("R4 ctrl oneshot", 2'd2, 32'h0000_0042);

      // R6 one-shot, count 5, divide by 1
      wr(2'd1, 32'd5);
      e0 = last_edge;
      push(e0 + 6, 8'h42, "R6");
      idle(3);
      rd("R5 cur after 3 ticks", 2'd3, 32'd2);
      idle(12);
      rd("R6 saturated", 2'd3, 32'd0);

      // R11 write to select 3 ignored
      wr(2'd3, 32'h1234);
      rd("R11 cur", 2'd3, 32'd0);
      rd("R11 init", 2'd1, 32'd5);

      // R5 restart
      wr(2'd1, 32'd10);
      idle(4);
      wr(2'd1, 32'd10);
      e0 = last_edge;
      push(e0 + 11, 8'h42, "R5");
      idle(16);

      // R7 periodic, divide by 2 (code 0), count 3
      wr(2'd1, 32'd0);
      wr(2'd2, 32'h0002_0055);
      wr(2'd0, 32'h0);
      wr(2'd1, 32'd3);
      e0 = last_edge;
      push(e0 + 8, 8'h55, "R7");
      push(e0 + 16, 8'h55, "R7");
      push(e0 + 24, 8'h55, "R7");
      idle(2);
      rd("R3 cur after one slow tick", 2'd3, 32'd2);
      idle(24);
      // R9 mask stops periodic events
      wr(2'd2, 32'h0003_0055);
      p0 = pulses;
      idle(30);
      chk("R9 no pulse while masked", pulses, p0);
      chk("R7 queue drained", q.size(), 0);

      // R8 zero count, periodic and one-shot
      wr(2'd1, 32'd0);
      wr(2'd2, 32'h0002_0055);
      wr(2'd0, 32'hB);
      p0 = pulses;
      idle(40);
      rd("R8 cur", 2'd3, 32'd0);
      wr(2'd2, 32'h0000_0055);
      wr(2'd1, 32'd0);
      idle(20);
      chk("R8 no pulse", pulses, p0);

      // R9 one-shot expiry while masked is lost
      wr(2'd2, 32'h0001_0077);
      wr(2'd1, 32'd4);
      idle(10);
      wr(2'd2, 32'h0000_0077);
      idle(20);
      chk("R9 lost expiry", pulses, p0);

      // R3 divide codes 3 (16 clocks) and 0xA (128 clocks)
      wr(2'd0, 32'h3);
      wr(2'd1, 32'd1);
      e0 = last_edge;
      push(e0 + 32, 8'h77, "R3 div16");
      idle(40);
      wr(2'd0, 32'hA);
      wr(2'd1, 32'd1);
      e0 = last_edge;
      push(e0 + 256, 8'h77, "R3 div128");
      idle(270);
      chk("R3 queue drained", q.size(), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule